// File: doc/BRIEF.md
# Wiper Register and Nonvolatile Store Controller

This block sits behind a serial slave interface and owns the registers of a single digitally controlled potentiometer. It keeps a volatile wiper position that drives a one-of-N tap decoder, a modelled nonvolatile initial value that the wiper takes after power-up, and a one-bit volatile selector that decides what address 0 means. Byte writes arrive as a strobe with an address and data byte. A bus STOP arrives as a one-cycle event. Reads are combinational from a read address.

With the selector clear, a write to address 0 moves the wiper at once and marks the value for storage. The following STOP then starts a self-timed store cycle, and the stored value changes when that cycle ends. With the selector set, address 0 reaches the wiper alone. After reset the wiper sits at midscale while a recall delay runs; then it takes the stored value. During the recall and during every store cycle the block raises busy and ignores writes and STOP events. Both delays are parameters counted in clock cycles.

Top module: `wiper_store_ctrl`

## Requirements
- R1: While reset is held, the wiper equals midscale (2^(WIPER_W-1), 40h for 7 bits), only tap bit 64 is set, busy is high, and a read of address 2 returns 00h.
- R2: After reset release, busy falls at the RECALL_CYC-th rising edge, and in that cycle the wiper takes the stored initial value (IVR_INIT until the first store completes).
- R3: A write to address 2 is accepted only for data 00h or 80h; any other value leaves the selector unchanged. A read of address 2 returns 80h when the selector is set and 00h when it is clear.
- R4: With the selector clear, a write to address 0 sets the wiper to data bits 6:0 at the next clock edge. Until a store cycle completes, a read of address 0 still returns the old stored value.
- R5: With the selector set, a write to address 0 updates only the wiper, a read of address 0 returns the wiper, and a later STOP leaves the stored value unchanged.
- R6: A STOP that follows a selector-clear write to address 0 holds busy high for exactly NVW_CYC rising edges, starting with the edge that samples the STOP. After that, a read of address 0 returns the written value.
- R7: A STOP with no pending store leaves busy low.
- R8: While busy is high, byte writes and STOP events have no effect on the wiper, the selector or the stored value.
- R9: Writes to address 1 or 3 change nothing, and reads of address 1 or 3 return 00h.
- R10: The tap output is one-hot with bit index equal to the wiper value. Data bit 7 of an address 0 write never affects the wiper.
- R11: Reading the stored value never changes the wiper, even when the two differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, acts as power-up |
| wr_stb | input | 1 | One-cycle strobe for a received data byte |
| wr_addr | input | ADDR_W (2) | Register address of the write |
| wr_data | input | DATA_W (8) | Data byte of the write |
| stop_evt | input | 1 | One-cycle bus STOP event |
| rd_addr | input | ADDR_W (2) | Register address of the read |
| rd_data | output | DATA_W (8) | Read data, combinational from rd_addr |
| busy | output | 1 | High during recall and during a store cycle |
| wiper | output | WIPER_W (7) | Current wiper position |
| tap | output | 2^WIPER_W (128) | One-hot tap select |

## Verification
The bound checker watches on every cycle that the tap select is one-hot and matches the wiper, and that a write accepted while idle lands in the wiper on the next edge. It also checks that writes during busy leave the wiper and selector untouched, and that a STOP starts a store cycle exactly when a store is pending. The exact length of the recall and store windows, the store value that becomes visible only afterwards, and the legality filter on selector values can only be shown by the bench. The bench sweeps every wiper code, every selector byte, and a store cycle that is hit by writes and a STOP while busy.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

   typedef enum logic [1:0] {
      SEQ_RECALL = 2'd0,
      SEQ_IDLE   = 2'd1,
      SEQ_NVWR   = 2'd2
   } seq_state_e;

   localparam int unsigned REG_WIPER = 0;
   localparam int unsigned REG_SPARE = 1;
   localparam int unsigned REG_SEL   = 2;

endpackage

// File: rtl/wsc_seq.sv
module wsc_seq #(
   parameter int unsigned RECALL_CYC = 16,
   parameter int unsigned NVW_CYC    = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stop_evt,
   input  logic nv_pend,
   output logic busy,
   output logic accept,
   output logic recall_ld,
   output logic nv_start,
   output logic nv_commit
);
   import wsc_pkg::*;

   localparam int unsigned MAX_CYC = (RECALL_CYC > NVW_CYC) ? RECALL_CYC : NVW_CYC;
   localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
   localparam logic [CNT_W-1:0] RECALL_LAST = CNT_W'(RECALL_CYC - 1);
   localparam logic [CNT_W-1:0] NVW_LAST    = CNT_W'(NVW_CYC - 1);

   generate
      if (RECALL_CYC < 1) begin : g_bad_recall
         $error("RECALL_CYC must be at least 1");
      end
      if (NVW_CYC < 1) begin : g_bad_nvw
         $error("NVW_CYC must be at least 1");
      end
   endgenerate

   seq_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;

   assign accept    = (state_q == SEQ_IDLE);
   assign busy      = !accept;
   assign recall_ld = (state_q == SEQ_RECALL) && (cnt_q == RECALL_LAST);
   assign nv_start  = accept && stop_evt && nv_pend;
   assign nv_commit = (state_q == SEQ_NVWR) && (cnt_q == NVW_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_RECALL;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            SEQ_RECALL: begin
               if (recall_ld) begin
                  state_q <= SEQ_IDLE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            SEQ_IDLE: begin
               if (nv_start) begin
                  state_q <= SEQ_NVWR;
                  cnt_q   <= '0;
               end
            end
            SEQ_NVWR: begin
               if (nv_commit) begin
                  state_q <= SEQ_IDLE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: begin
               state_q <= SEQ_IDLE;
               cnt_q   <= '0;
            end
         endcase
      end
   end

endmodule

// File: rtl/wsc_regs.sv
module wsc_regs #(
   parameter int unsigned WIPER_W  = 7,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned ADDR_W   = 2,
   parameter logic [WIPER_W-1:0] IVR_INIT = WIPER_W'(1 << (WIPER_W - 1))
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              recall_ld,
   input  logic              nv_start,
   input  logic              nv_commit,
   output logic [WIPER_W-1:0] wiper,
   output logic              vol_sel,
   output logic              nv_pend
);
   import wsc_pkg::*;

   localparam logic [WIPER_W-1:0] MIDSCALE = WIPER_W'(1 << (WIPER_W - 1));
   localparam int unsigned        PAD_W    = DATA_W - WIPER_W;

   generate
      if (WIPER_W >= DATA_W) begin : g_bad_width
         $error("WIPER_W must be smaller than DATA_W");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must cover address 2");
      end
   endgenerate

   logic [WIPER_W-1:0] wiper_q;
   logic [WIPER_W-1:0] ivr_q;
   logic [WIPER_W-1:0] pend_val_q;
   logic [WIPER_W-1:0] commit_val_q;
   logic               sel_q;
   logic               pend_q;

   logic hit_wiper;
   logic hit_sel;
   logic sel_legal;

   assign hit_wiper = accept && wr_stb && (wr_addr == ADDR_W'(REG_WIPER));
   assign hit_sel   = accept && wr_stb && (wr_addr == ADDR_W'(REG_SEL));
   assign sel_legal = (wr_data[DATA_W-2:0] == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wiper_q      <= MIDSCALE;
         ivr_q        <= IVR_INIT;
         pend_val_q   <= '0;
         commit_val_q <= '0;
         sel_q        <= 1'b0;
         pend_q       <= 1'b0;
      end else begin
         if (recall_ld) begin
            wiper_q <= ivr_q;
         end else if (hit_wiper) begin
            wiper_q <= wr_data[WIPER_W-1:0];
         end

         if (nv_start) begin
            pend_q       <= 1'b0;
            commit_val_q <= pend_val_q;
         end else if (hit_wiper && !sel_q) begin
            pend_q     <= 1'b1;
            pend_val_q <= wr_data[WIPER_W-1:0];
         end

         if (nv_commit) begin
            ivr_q <= commit_val_q;
         end

         if (hit_sel && sel_legal) begin
            sel_q <= wr_data[DATA_W-1];
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(REG_WIPER)) begin
         rd_data = sel_q ? {{PAD_W{1'b0}}, wiper_q} : {{PAD_W{1'b0}}, ivr_q};
      end else if (rd_addr == ADDR_W'(REG_SEL)) begin
         rd_data = {sel_q, {(DATA_W-1){1'b0}}};
      end
   end

   assign wiper   = wiper_q;
   assign vol_sel = sel_q;
   assign nv_pend = pend_q;

endmodule

// File: rtl/wsc_tap_dec.sv
module wsc_tap_dec #(
   parameter int unsigned WIPER_W = 7
) (
   input  logic [WIPER_W-1:0]        wiper,
   output logic [(1 << WIPER_W)-1:0] tap
);
   localparam int unsigned N_TAP = 1 << WIPER_W;

   generate
      if (WIPER_W > 10) begin : g_bad_taps
         $error("WIPER_W too large for a flat tap decoder");
      end
      for (genvar i = 0; i < N_TAP; i++) begin : g_tap
         assign tap[i] = (wiper == WIPER_W'(i));
      end
   endgenerate

endmodule

// File: rtl/wiper_store_ctrl.sv
module wiper_store_ctrl #(
   parameter int unsigned WIPER_W    = 7,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned ADDR_W     = 2,
   parameter int unsigned RECALL_CYC = 16,
   parameter int unsigned NVW_CYC    = 64,
   parameter logic [WIPER_W-1:0] IVR_INIT = WIPER_W'(1 << (WIPER_W - 1))
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_stb,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic                       stop_evt,
   input  logic [ADDR_W-1:0]          rd_addr,
   output logic [DATA_W-1:0]          rd_data,
   output logic                       busy,
   output logic [WIPER_W-1:0]         wiper,
   output logic [(1 << WIPER_W)-1:0]  tap
);

   logic accept;
   logic recall_ld;
   logic nv_start;
   logic nv_commit;
   logic nv_pend;
   logic vol_sel;

   wsc_seq #(
      .RECALL_CYC(RECALL_CYC),
      .NVW_CYC   (NVW_CYC)
   ) i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .stop_evt (stop_evt),
      .nv_pend  (nv_pend),
      .busy     (busy),
      .accept   (accept),
      .recall_ld(recall_ld),
      .nv_start (nv_start),
      .nv_commit(nv_commit)
   );

   wsc_regs #(
      .WIPER_W (WIPER_W),
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W),
      .IVR_INIT(IVR_INIT)
   ) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .wr_stb   (wr_stb),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .recall_ld(recall_ld),
      .nv_start (nv_start),
      .nv_commit(nv_commit),
      .wiper    (wiper),
      .vol_sel  (vol_sel),
      .nv_pend  (nv_pend)
   );

   wsc_tap_dec #(
      .WIPER_W(WIPER_W)
   ) i_dec (
      .wiper(wiper),
      .tap  (tap)
   );

endmodule

// File: rtl/wsc_chk.sv
module wsc_chk #(
   parameter int unsigned WIPER_W = 7,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned ADDR_W  = 2
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      busy,
   input logic                      stop_evt,
   input logic                      nv_pend,
   input logic                      vol_sel,
   input logic                      wr_stb,
   input logic [ADDR_W-1:0]         wr_addr,
   input logic [DATA_W-1:0]         wr_data,
   input logic [WIPER_W-1:0]        wiper,
   input logic [(1 << WIPER_W)-1:0] tap
);

   // R10: exactly one tap is selected
   p_tap_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tap) == 1);

   // R10: the selected tap is the wiper position
   p_tap_index_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tap[wiper] == 1'b1);

   // R4 / R5: an accepted address 0 write lands on the next edge
   p_wiper_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && wr_stb && wr_addr == '0) |=> (wiper == $past(wr_data[WIPER_W-1:0])));

   // R8: wiper holds while a store cycle keeps running
   p_busy_wiper_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(wiper));

   // R8: selector writes during busy are dropped
   p_busy_sel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_stb) |=> $stable(vol_sel));

   // R6: STOP with a pending store enters the store cycle
   p_stop_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && stop_evt && nv_pend) |=> busy);

   // R7: STOP without a pending store stays idle
   p_stop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && stop_evt && !nv_pend) |=> !busy);

endmodule

bind wiper_store_ctrl wsc_chk #(
   .WIPER_W(WIPER_W),
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy    (busy),
   .stop_evt(stop_evt),
   .nv_pend (nv_pend),
   .vol_sel (vol_sel),
   .wr_stb  (wr_stb),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .wiper   (wiper),
   .tap     (tap)
);

// File: tb/test_wiper_store_ctrl.sv
module test_wiper_store_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 7;
   localparam int DW         = 8;
   localparam int AW         = 2;
   localparam int RCYC       = 4;
   localparam int NCYC       = 5;
   localparam logic [W-1:0] INIT = 7'h15;
   localparam int NT         = 1 << W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_stb = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          stop_evt = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          busy;
   logic [W-1:0]  wiper;
   logic [NT-1:0] tap;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   wiper_store_ctrl #(
      .WIPER_W   (W),
      .DATA_W    (DW),
      .ADDR_W    (AW),
      .RECALL_CYC(RCYC),
      .NVW_CYC   (NCYC),
      .IVR_INIT  (INIT)
   ) i_wiper_store_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_stb),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .stop_evt(stop_evt),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .busy    (busy),
      .wiper   (wiper),
      .tap     (tap)
   );

   task automatic check(input string req, input logic [NT-1:0] act, input logic [NT-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // called at a negedge, returns at the next negedge
   task automatic wr(input int a, input int d);
      wr_stb  = 1'b1;
      wr_addr = AW'(a);
      wr_data = DW'(d);
      @(posedge clk);
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   task automatic stop_pulse();
      stop_evt = 1'b1;
      @(posedge clk);
      @(negedge clk);
      stop_evt = 1'b0;
   endtask

   task automatic rd(input int a, output logic [DW-1:0] v);
      rd_addr = AW'(a);
      #1;
      v = rd_data;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin : stim
      logic [DW-1:0] v;
      logic [DW-1:0] sel_exp;
      int n;

      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 wiper midscale", NT'(wiper), NT'(7'h40));
      check("R1 tap midscale", tap, NT'(1) << 64);
      check("R1 busy", NT'(busy), NT'(1));
      rd(2, v);
      check("R1 selector", NT'(v), NT'(0));

      // R2: recall timing and value
      rst_n = 1'b1;
      n = 0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (!busy) break;
         n++;
      end
      check("R2 recall edges", NT'(n + 1), NT'(RCYC));
      check("R2 recalled wiper", NT'(wiper), NT'(INIT));
      rd(0, v);
      check("R2 stored value read", NT'(v), NT'(INIT));

      // R9: unused addresses
      wr(1, 8'h55);
      wr(3, 8'h80);
      rd(1, v);
      check("R9 read addr1", NT'(v), NT'(0));
      rd(3, v);
      check("R9 read addr3", NT'(v), NT'(0));
      check("R9 wiper untouched", NT'(wiper), NT'(INIT));
      rd(2, v);
      check("R9 selector untouched", NT'(v), NT'(0));

      // R3: sweep of all selector bytes
      sel_exp = 8'h00;
      for (int d = 0; d < 256; d++) begin
         wr(2, d);
         if (d == 8'h00 || d == 8'h80) sel_exp = DW'(d);
         rd(2, v);
         check("R3 selector filter", NT'(v), NT'(sel_exp));
      end
      check("R3 wiper untouched", NT'(wiper), NT'(INIT));

      // R5 / R10: volatile sweep with selector set, bit 7 toggled
      wr(2, 8'h80);
      for (int p = 0; p < NT; p++) begin
         wr(0, ((p & 1) << 7) | p);
         check("R10 wiper value", NT'(wiper), NT'(p));
         check("R10 tap onehot", tap, NT'(1) << p);
         rd(0, v);
         check("R5 read returns wiper", NT'(v), NT'(p));
         check("R5 no busy", NT'(busy), NT'(0));
      end

      // R7 / R5: STOP after volatile-only writes
      stop_pulse();
      check("R7 no busy after stop", NT'(busy), NT'(0));
      @(negedge clk);
      check("R7 still idle", NT'(busy), NT'(0));
      wr(2, 8'h00);
      rd(0, v);
      check("R5 stored value unchanged", NT'(v), NT'(INIT));

      // R4: selector clear, write both
      wr(0, 8'h33);
      check("R4 wiper updated", NT'(wiper), NT'(7'h33));
      rd(0, v);
      check("R4 stored value old before store", NT'(v), NT'(INIT));
      check("R6 idle before stop", NT'(busy), NT'(0));

      // R6 / R8: store cycle hit by writes and a STOP
      stop_pulse();
      n = 0;
      for (int k = 0; k < 12; k++) begin
         if (busy) n++;
         wr_stb   = (k < 2);
         wr_addr  = (k == 0) ? AW'(0) : AW'(2);
         wr_data  = (k == 0) ? 8'h7F : 8'h80;
         stop_evt = (k == 2);
         @(posedge clk);
         @(negedge clk);
      end
      wr_stb   = 1'b0;
      stop_evt = 1'b0;
      check("R6 store busy length", NT'(n), NT'(NCYC));
      check("R8 wiper kept", NT'(wiper), NT'(7'h33));
      rd(2, v);
      check("R8 selector kept", NT'(v), NT'(0));
      rd(0, v);
      check("R6 stored value after cycle", NT'(v), NT'(7'h33));
      stop_pulse();
      check("R7 stop after store idle", NT'(busy), NT'(0));

      // R11: reading the stored value leaves the wiper alone
      wr(2, 8'h80);
      wr(0, 8'h11);
      wr(2, 8'h00);
      rd(0, v);
      check("R11 stored value read", NT'(v), NT'(7'h33));
      @(negedge clk);
      check("R11 wiper unchanged", NT'(wiper), NT'(7'h11));

      // R4 / R6 / R10: bit 7 dropped on a stored write
      wr(0, 8'hAA);
      check("R10 bit7 ignored", NT'(wiper), NT'(7'h2A));
      stop_pulse();
      repeat (NCYC + 1) @(negedge clk);
      rd(0, v);
      check("R6 stored 2A", NT'(v), NT'(7'h2A));
      check("R6 idle again", NT'(busy), NT'(0));

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule